// File: doc/BRIEF.md
# Factory Bad-Block Screening Engine

This block screens a NAND memory for factory-marked bad blocks at start-up. After a start pulse it asks for pages through a generic read-request interface, block after block from index zero upward and page after page within a block. Each page comes back as a byte stream. On a new device every byte of a usable block is erased (FFh), so the engine compares each byte with FFh.

At the first byte that differs, the engine records the block as bad. It tells the memory side to stop the stream and moves straight on to page zero of the next block. The remaining pages and bytes of that block are not read. When the last block has been handled, a sticky done flag rises.

The result is held as a bitmap with one bit per block, together with a count of bad blocks. A device-failure flag rises when the count goes over the allowed limit. Another agent can mark a block bad while the system runs, for example after a program or erase reports a failed status. A combinational query port returns the flag of any block. Erase requests pass through the engine, and an erase aimed at a block recorded as bad is held back.

Top module: `blk_screen`

## Requirements
- R1: After reset, `scan_done`, `rd_req`, `rd_abort` and `dev_fail` are 0, `bad_cnt` is 0 and every bit of `bad_map` is 0.
- R2: After `start`, page reads are requested in ascending block order and in ascending page order within a block. Each request holds `rd_req` high until `rd_gnt`. For a block with no mismatch, every page is requested exactly once.
- R3: A block whose every byte of every page reads FFh leaves its `bad_map` bit at 0.
- R4: The first byte received with `rd_vld` high that is not FFh raises `rd_abort` in that same cycle and sets the block's `bad_map` bit. The next request is then page 0 of the next block, and no further page of the bad block is requested.
- R5: `bad_cnt` equals the number of 1 bits in `bad_map` and never decreases. `dev_fail` is 1 exactly when `bad_cnt` is greater than `MAX_BAD`.
- R6: After the last block is finished, `scan_done` rises and stays high until reset, and `rd_req` stays low. A `start` pulse given while the engine is not idle has no effect.
- R7: A `mark_vld` pulse sets `bad_map[mark_idx]` on the next clock edge. Marking a block that is already bad leaves `bad_cnt` unchanged.
- R8: `qry_bad` equals `bad_map[qry_idx]` in the same cycle, with no clock edge in between.
- R9: `er_go` equals `er_req` when the block at `er_idx` is not marked bad, and is 0 when it is marked bad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Pulse that begins the scan from idle |
| rd_req | output | 1 | Page read request, held until granted |
| rd_blk | output | BW | Block index of the requested page |
| rd_page | output | PW | Page index within the block |
| rd_gnt | input | 1 | Memory side accepts the request |
| rd_vld | input | 1 | A byte of the page is present on `rd_byte` |
| rd_byte | input | 8 | Returned data byte |
| rd_abort | output | 1 | Stop the current page stream (mismatch seen) |
| mark_vld | input | 1 | Run-time request to mark a block bad |
| mark_idx | input | BW | Block to mark |
| qry_idx | input | BW | Block to look up |
| qry_bad | output | 1 | Bad flag of `qry_idx` |
| er_req | input | 1 | Erase request from the controller |
| er_idx | input | BW | Block the erase targets |
| er_go | output | 1 | Erase allowed to proceed |
| bad_map | output | NUM_BLOCKS | One flag per block, 1 = bad |
| bad_cnt | output | CW | Number of bad blocks |
| dev_fail | output | 1 | More bad blocks than `MAX_BAD` |
| scan_done | output | 1 | Scan of all blocks finished |

## Verification
The assertions take the memory side to behave as follows. Bytes arrive only after a grant and never more than one page's worth per request. `rd_vld` falls in the cycle after `rd_abort`. Block indices on `mark_idx`, `qry_idx` and `er_idx` lie below `NUM_BLOCKS`. The bench's memory model grants a request one cycle after it sees it and then streams one byte per cycle. It samples `rd_abort` between clock edges and stops driving bytes right after an aborted one. All indices the bench drives stay inside the scaled-down array of 8 blocks, each of 4 pages of 6 bytes.

// File: rtl/blk_screen_pkg.sv
package blk_screen_pkg;
  typedef enum logic [1:0] {
    SC_IDLE   = 2'd0,
    SC_REQ    = 2'd1,
    SC_STREAM = 2'd2,
    SC_DONE   = 2'd3
  } scan_st_e;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/blk_screen_rst_sync.sv
module blk_screen_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/blk_screen_seq.sv
module blk_screen_seq
  import blk_screen_pkg::*;
#(
  parameter int NUM_BLOCKS = 1024,
  parameter int PAGES      = 32,
  parameter int BYTES      = 528,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int PW = $clog2(PAGES),
  localparam int XW = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          rd_req,
  output logic [BW-1:0] rd_blk,
  output logic [PW-1:0] rd_page,
  input  logic          rd_gnt,
  input  logic          rd_vld,
  input  logic [7:0]    rd_byte,
  output logic          rd_abort,
  output logic          scan_mark,
  output logic [BW-1:0] scan_idx,
  output logic          scan_done
);
  localparam logic [BW-1:0] BLK_LAST  = BW'(NUM_BLOCKS - 1);
  localparam logic [PW-1:0] PAGE_LAST = PW'(PAGES - 1);
  localparam logic [XW-1:0] COL_LAST  = XW'(BYTES - 1);

  scan_st_e      st_q, st_d;
  logic [BW-1:0] blk_q, blk_d;
  logic [PW-1:0] pg_q, pg_d;
  logic [XW-1:0] col_q, col_d;
  logic          take, mism, blk_end;

  assign take    = (st_q == SC_STREAM) && rd_vld;
  assign mism    = take && (rd_byte != ERASED_BYTE);
  assign blk_end = take && (mism || ((col_q == COL_LAST) && (pg_q == PAGE_LAST)));

  always_comb begin
    st_d  = st_q;
    blk_d = blk_q;
    pg_d  = pg_q;
    col_d = col_q;
    unique case (st_q)
      SC_IDLE: begin
        if (start) begin
          st_d  = SC_REQ;
          blk_d = '0;
          pg_d  = '0;
        end
      end
      SC_REQ: begin
        if (rd_gnt) begin
          st_d  = SC_STREAM;
          col_d = '0;
        end
      end
      SC_STREAM: begin
        if (blk_end) begin
          if (blk_q == BLK_LAST) begin
            st_d = SC_DONE;
          end else begin
            st_d  = SC_REQ;
            blk_d = blk_q + 1'b1;
            pg_d  = '0;
          end
        end else if (take && (col_q == COL_LAST)) begin
          st_d = SC_REQ;
          pg_d = pg_q + 1'b1;
        end else if (take) begin
          col_d = col_q + 1'b1;
        end
      end
      default: st_d = SC_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SC_IDLE;
      blk_q <= '0;
      pg_q  <= '0;
      col_q <= '0;
    end else begin
      st_q  <= st_d;
      blk_q <= blk_d;
      pg_q  <= pg_d;
      col_q <= col_d;
    end
  end

  assign rd_req    = (st_q == SC_REQ);
  assign rd_blk    = blk_q;
  assign rd_page   = pg_q;
  assign rd_abort  = mism;
  assign scan_mark = mism;
  assign scan_idx  = blk_q;
  assign scan_done = (st_q == SC_DONE);
endmodule

// File: rtl/blk_screen_table.sv
module blk_screen_table #(
  parameter int NUM_BLOCKS = 1024,
  parameter int MAX_BAD    = 20,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int CW = $clog2(NUM_BLOCKS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_mark,
  input  logic [BW-1:0]         scan_idx,
  input  logic                  mark_vld,
  input  logic [BW-1:0]         mark_idx,
  input  logic [BW-1:0]         qry_idx,
  output logic                  qry_bad,
  input  logic                  er_req,
  input  logic [BW-1:0]         er_idx,
  output logic                  er_go,
  output logic [NUM_BLOCKS-1:0] bad_map,
  output logic [CW-1:0]         bad_cnt,
  output logic                  dev_fail
);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_BAD);

  logic [NUM_BLOCKS-1:0] map_q;
  logic [CW-1:0]         cnt_q, cnt_d;
  logic                  scan_new, ext_new, cnt_en;

  assign scan_new = scan_mark && !map_q[scan_idx];
  assign ext_new  = mark_vld && !map_q[mark_idx] &&
                    !(scan_mark && (mark_idx == scan_idx));
  assign cnt_en   = scan_new || ext_new;
  assign cnt_d    = cnt_q + CW'(scan_new) + CW'(ext_new);

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_flag
    logic set_b;
    assign set_b = (scan_mark && (scan_idx == BW'(b))) ||
                   (mark_vld && (mark_idx == BW'(b)));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     map_q[b] <= 1'b0;
      else if (set_b) map_q[b] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign qry_bad  = map_q[qry_idx];
  assign er_go    = er_req && !map_q[er_idx];
  assign bad_map  = map_q;
  assign bad_cnt  = cnt_q;
  assign dev_fail = (cnt_q > LIMIT);
endmodule

// File: rtl/blk_screen.sv
module blk_screen #(
  parameter int NUM_BLOCKS = 1024,
  parameter int PAGES      = 32,
  parameter int BYTES      = 528,
  parameter int MAX_BAD    = 20,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int PW = $clog2(PAGES),
  localparam int CW = $clog2(NUM_BLOCKS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  rd_req,
  output logic [BW-1:0]         rd_blk,
  output logic [PW-1:0]         rd_page,
  input  logic                  rd_gnt,
  input  logic                  rd_vld,
  input  logic [7:0]            rd_byte,
  output logic                  rd_abort,
  input  logic                  mark_vld,
  input  logic [BW-1:0]         mark_idx,
  input  logic [BW-1:0]         qry_idx,
  output logic                  qry_bad,
  input  logic                  er_req,
  input  logic [BW-1:0]         er_idx,
  output logic                  er_go,
  output logic [NUM_BLOCKS-1:0] bad_map,
  output logic [CW-1:0]         bad_cnt,
  output logic                  dev_fail,
  output logic                  scan_done
);
  logic          rst_sync_n;
  logic          scan_mark;
  logic [BW-1:0] scan_idx;

  blk_screen_rst_sync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  blk_screen_seq #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .PAGES      (PAGES),
    .BYTES      (BYTES)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start     (start),
    .rd_req    (rd_req),
    .rd_blk    (rd_blk),
    .rd_page   (rd_page),
    .rd_gnt    (rd_gnt),
    .rd_vld    (rd_vld),
    .rd_byte   (rd_byte),
    .rd_abort  (rd_abort),
    .scan_mark (scan_mark),
    .scan_idx  (scan_idx),
    .scan_done (scan_done)
  );

  blk_screen_table #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .MAX_BAD    (MAX_BAD)
  ) tbl_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .scan_mark (scan_mark),
    .scan_idx  (scan_idx),
    .mark_vld  (mark_vld),
    .mark_idx  (mark_idx),
    .qry_idx   (qry_idx),
    .qry_bad   (qry_bad),
    .er_req    (er_req),
    .er_idx    (er_idx),
    .er_go     (er_go),
    .bad_map   (bad_map),
    .bad_cnt   (bad_cnt),
    .dev_fail  (dev_fail)
  );
endmodule

// File: rtl/blk_screen_chk.sv
module blk_screen_chk #(
  parameter int NUM_BLOCKS = 1024,
  parameter int MAX_BAD    = 20,
  localparam int BW = $clog2(NUM_BLOCKS),
  localparam int CW = $clog2(NUM_BLOCKS + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  rd_req,
  input logic                  rd_vld,
  input logic [7:0]            rd_byte,
  input logic                  rd_abort,
  input logic                  mark_vld,
  input logic [BW-1:0]         mark_idx,
  input logic                  er_req,
  input logic                  er_go,
  input logic [NUM_BLOCKS-1:0] bad_map,
  input logic [CW-1:0]         bad_cnt,
  input logic                  dev_fail,
  input logic                  scan_done
);
  // R4
  abort_on_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_abort |-> (rd_vld && (rd_byte != 8'hFF)));

  // R5
  cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (bad_cnt >= $past(bad_cnt)));

  // R5
  cnt_matches_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cnt == CW'($countones(bad_map)));

  // R5
  fail_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_fail == (int'(bad_cnt) > MAX_BAD));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> scan_done);

  // R6
  no_req_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !rd_req);

  // R7
  mark_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_vld |=> bad_map[$past(mark_idx)]);

  // R9
  erase_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    er_go |-> er_req);
endmodule

bind blk_screen blk_screen_chk #(
  .NUM_BLOCKS (NUM_BLOCKS),
  .MAX_BAD    (MAX_BAD)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .rd_req    (rd_req),
  .rd_vld    (rd_vld),
  .rd_byte   (rd_byte),
  .rd_abort  (rd_abort),
  .mark_vld  (mark_vld),
  .mark_idx  (mark_idx),
  .er_req    (er_req),
  .er_go     (er_go),
  .bad_map   (bad_map),
  .bad_cnt   (bad_cnt),
  .dev_fail  (dev_fail),
  .scan_done (scan_done)
);

// File: tb/blk_screen_tb_top.sv
module blk_screen_tb_top;
  localparam int NB = 8;
  localparam int NP = 4;
  localparam int NX = 6;
  localparam int MB = 2;
  localparam int BW = $clog2(NB);
  localparam int PW = $clog2(NP);
  localparam int CW = $clog2(NB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          rd_req, rd_abort, qry_bad, er_go, dev_fail, scan_done;
  logic [BW-1:0] rd_blk;
  logic [PW-1:0] rd_page;
  logic          rd_gnt = 1'b0, rd_vld = 1'b0;
  logic [7:0]    rd_byte = 8'hFF;
  logic          mark_vld = 1'b0, er_req = 1'b0;
  logic [BW-1:0] mark_idx = '0, qry_idx = '0, er_idx = '0;
  logic [NB-1:0] bad_map;
  logic [CW-1:0] bad_cnt;

  int n_run = 0, n_fail = 0;

  // memory model state
  bit  mdl_on = 0;
  bit  is_bad [NB];
  int  bad_pg [NB];
  int  bad_col[NB];
  int  n_req = 0, n_abort = 0, exp_b = 0, exp_p = 0;

  always #2.5 clk = ~clk;

  blk_screen #(
    .NUM_BLOCKS (NB), .PAGES (NP), .BYTES (NX), .MAX_BAD (MB)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .start (start),
    .rd_req (rd_req), .rd_blk (rd_blk), .rd_page (rd_page),
    .rd_gnt (rd_gnt), .rd_vld (rd_vld), .rd_byte (rd_byte),
    .rd_abort (rd_abort), .mark_vld (mark_vld), .mark_idx (mark_idx),
    .qry_idx (qry_idx), .qry_bad (qry_bad), .er_req (er_req),
    .er_idx (er_idx), .er_go (er_go), .bad_map (bad_map),
    .bad_cnt (bad_cnt), .dev_fail (dev_fail), .scan_done (scan_done)
  );

  task automatic check(input string req, input longint act, input longint exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory side: grant, then stream bytes until page end or abort
  initial begin
    forever begin
      @(negedge clk);
      rd_vld = 1'b0;
      if (mdl_on && rd_req) begin
        n_req++;
        check("R2", rd_blk, exp_b, "requested block");
        check("R2", rd_page, exp_p, "requested page");
        rd_gnt = 1'b1;
        @(negedge clk);
        rd_gnt = 1'b0;
        begin
          bit ab;
          bit want;
          ab = 0;
          for (int i = 0; i < NX; i++) begin
            want = is_bad[exp_b] && bad_pg[exp_b] == exp_p && bad_col[exp_b] == i;
            rd_vld  = 1'b1;
            rd_byte = want ? 8'h5A : 8'hFF;
            #1;
            ab = rd_abort;
            check("R4", ab, want, "abort at mismatch byte");
            @(negedge clk);
            if (ab) break;
          end
          rd_vld = 1'b0;
          if (ab) n_abort++;
          if (ab || exp_p == NP - 1) begin
            exp_b++;
            exp_p = 0;
          end else begin
            exp_p++;
          end
        end
      end
    end
  end

  task automatic do_reset();
    mdl_on = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_scan();
    n_req = 0; n_abort = 0; exp_b = 0; exp_p = 0;
    mdl_on = 1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 5000 && !scan_done; k++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    for (int b = 0; b < NB; b++) is_bad[b] = 0;
    do_reset();
    check("R1", scan_done, 0, "done after reset");
    check("R1", rd_req, 0, "rd_req after reset");
    check("R1", rd_abort, 0, "abort after reset");
    check("R1", bad_cnt, 0, "count after reset");
    check("R1", bad_map, 0, "map after reset");
    check("R1", dev_fail, 0, "fail after reset");
  endtask

  task automatic t_clean_scan();
    run_scan();
    check("R6", scan_done, 1, "done after clean scan");
    check("R2", n_req, NB * NP, "page requests, clean");
    check("R3", bad_map, 0, "map after clean scan");
    check("R3", bad_cnt, 0, "count after clean scan");
    repeat (4) @(negedge clk);
    check("R6", rd_req, 0, "no request after done");
    check("R6", scan_done, 1, "done sticky");
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", rd_req, 0, "start ignored when done");
  endtask

  task automatic pulse_mark(input int idx);
    mark_idx = BW'(idx);
    mark_vld = 1'b1;
    @(negedge clk);
    mark_vld = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_mark_query();
    pulse_mark(0);
    pulse_mark(5);
    check("R7", bad_map, 8'b0010_0001, "map after two marks");
    check("R5", bad_cnt, 2, "count at limit");
    check("R5", dev_fail, 0, "no fail at limit");
    pulse_mark(5);
    check("R7", bad_cnt, 2, "re-mark keeps count");
    pulse_mark(6);
    check("R5", bad_cnt, 3, "count over limit");
    check("R5", dev_fail, 1, "fail over limit");
    for (int b = 0; b < NB; b++) begin
      qry_idx = BW'(b);
      #1;
      check("R8", qry_bad, (b == 0 || b == 5 || b == 6), "query flag");
    end
  endtask

  task automatic t_erase();
    er_idx = 3'd5; er_req = 1'b1; #1;
    check("R9", er_go, 0, "erase to bad block held");
    er_idx = 3'd3; #1;
    check("R9", er_go, 1, "erase to good block passes");
    er_req = 1'b0; #1;
    check("R9", er_go, 0, "no request no erase");
    @(negedge clk);
  endtask

  task automatic t_bad_scan();
    for (int b = 0; b < NB; b++) is_bad[b] = 0;
    is_bad[1] = 1; bad_pg[1] = 0;      bad_col[1] = 0;
    is_bad[4] = 1; bad_pg[4] = NP - 1; bad_col[4] = NX - 1;
    is_bad[7] = 1; bad_pg[7] = 2;      bad_col[7] = 3;
    do_reset();
    run_scan();
    check("R6", scan_done, 1, "done after mixed scan");
    check("R4", bad_map, 8'b1001_0010, "map after mixed scan");
    check("R4", n_abort, 3, "abort count");
    check("R2", n_req, 5 * NP + 1 + NP + 3, "page requests, mixed");
    check("R5", bad_cnt, 3, "count after mixed scan");
    check("R5", dev_fail, 1, "fail after mixed scan");
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_clean_scan();
    t_mark_query();
    t_erase();
    t_bad_scan();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule